// File: doc/BRIEF.md
# Edge/Level Interrupt Controller with Acknowledge-Gated Outputs

This block gathers 32 interrupt lines into two outputs, a normal request (IRQ) and a fast request (FIQ). Each line has its own configuration word that gives a 5-bit priority, a sense type (edge or level) and a bit that routes the line to the fast class. Incoming lines are synchronised and latched into a pending register. A mask register removes lines from arbitration. For each class, a priority picker selects a winner among the pending, unmasked lines routed to that class.

Each class raises its output only while it is armed. When the output rises, the block latches the winning line index and disarms the class. The output then stays high until software acknowledges through the control register. An acknowledge re-arms the class and arbitrates again in the same cycle. Software reads the latched index from a winner register. That read also retires the pending bit of an edge-type winner. A software-set register lets software inject one line as though it had fired.

Top module: `lvl_edge_intc`

## Requirements
- R1: After a synchronous active-low reset, mask reads 0xFFFFFFFF. Pending, every line configuration word and both outputs read 0.
- R2: The pending bit of an edge line (sense 0) sets only on a low-to-high transition of its synchronised input. A line held high does not set it again after it was cleared.
- R3: The pending bit of a level line (sense 1) is set while its input is high. It clears when the input falls.
- R4: A write to pending (offset 0x00) ANDs the written value into pending. Bits of level lines whose input is currently high stay set.
- R5: A read of the IRQ winner (0x10) or FIQ winner (0x14) returns the latched line index in bits 4:0. It clears that line's pending bit only if the line is edge-type.
- R6: The candidates of a class are the lines that are pending and unmasked, with routing bit 1 for FIQ and routing bit 0 for IRQ. The numerically smallest priority wins. On a tie, the higher line index wins.
- R7: An armed class with at least one candidate latches its winner and raises its output. The output and winner then stay unchanged, whatever new lines arrive, until that class is acknowledged.
- R8: Writing control (0x18) with bit 0 acknowledges IRQ and bit 1 acknowledges FIQ. The output drops and the class re-arms, unless a candidate exists in that cycle. In that case the output stays high and the new winner is latched at once.
- R9: A mask bit set to 1 keeps its line out of arbitration but not out of pending. Clearing the mask bit lets the line win on the next edge.
- R10: Writing the software-set register (0x9C) sets the pending bit of only the lowest-indexed line among the written ones bits. The register reads 0.
- R11: The configuration word of line n sits at 0x1C+4n. Priority is in bits 6:2, sense in bit 1 and routing in bit 0. Other bits read 0, and control reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 32 | Interrupt lines, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; qualifies read side effects |
| addr | input | 8 | Byte address of the word register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq_o | output | 1 | Normal-class interrupt request |
| fiq_o | output | 1 | Fast-class interrupt request |

## Verification
The hardest situation to create is arbitration over many simultaneous candidates. Lines reach pending through a synchroniser one at a time, and an armed class would latch the first one that arrived. The stimulus therefore masks every line first, raises a whole pattern of lines, and then unmasks them all in one write. The picker then sees the full set at once. This is repeated over several bit patterns and two priority layouts, one of them rich in ties. A second delicate case is an acknowledge that meets a waiting candidate. The stimulus keeps one line pending behind a latched winner, then acknowledges and checks that the output never drops and the winner changes.

// File: rtl/intc_pkg.sv
// Shared constants of the interrupt controller: sizes and register offsets.
package intc_pkg;
    localparam int unsigned LINE_CNT = 32;
    localparam int unsigned PRIO_W   = 5;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned ADDR_W   = 8;

    localparam logic [7:0] OFS_PEND    = 8'h00;
    localparam logic [7:0] OFS_MASK    = 8'h04;
    localparam logic [7:0] OFS_WIN_IRQ = 8'h10;
    localparam logic [7:0] OFS_WIN_FIQ = 8'h14;
    localparam logic [7:0] OFS_CTRL    = 8'h18;
    localparam logic [7:0] OFS_CFG     = 8'h1C;
    localparam logic [7:0] OFS_SWSET   = 8'h9C;
endpackage

// File: rtl/intc_line_bank.sv
// Input synchroniser, edge detector and pending register for all lines.
// Assumes line_in is asynchronous; SYNC flops precede the edge compare.
// Within one cycle a set event wins over any clear event on the same line.
module intc_line_bank #(
    parameter int N    = 32,
    parameter int SYNC = 2,
    localparam int IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  line_in,
    input  logic [N-1:0]  sense,
    input  logic          pend_wr,
    input  logic [N-1:0]  pend_wdata,
    input  logic          pick_clr,
    input  logic [IW-1:0] pick_idx,
    input  logic          sw_wr,
    input  logic [N-1:0]  sw_wdata,
    output logic [N-1:0]  pend
);
    logic [SYNC-1:0][N-1:0] sync_q;
    logic [N-1:0]           prev_q;
    logic [N-1:0]           cur;
    logic [N-1:0]           sw_one;

    // Synchroniser chain plus one stage holding the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= line_in;
            for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
            prev_q <= sync_q[SYNC-1];
        end
    end

    assign cur    = sync_q[SYNC-1];
    // Isolate the lowest set bit of the software-set value.
    assign sw_one = sw_wr ? (sw_wdata & (~sw_wdata + N'(1))) : '0;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise_w, fall_w, set_w, clr_w;
        assign rise_w = cur[g] & ~prev_q[g];
        assign fall_w = ~cur[g] & prev_q[g];
        assign set_w  = (sense[g] ? cur[g] : rise_w) | sw_one[g];
        assign clr_w  = (pend_wr & ~pend_wdata[g])
                      | (pick_clr & (pick_idx == IW'(g)) & ~sense[g])
                      | (sense[g] & fall_w);
        // Pending bit update: clears first, then sets.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[g] <= 1'b0;
            else        pend[g] <= (pend[g] & ~clr_w) | set_w;
        end
    end
endmodule

// File: rtl/intc_prio_arb.sv
// Combinational priority picker: lowest priority value wins, ties go to
// the higher index. Assumes nothing about the candidate set; any=0 means
// no candidate and pick is then 0.
module intc_prio_arb #(
    parameter int N   = 32,
    parameter int PW  = 5,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 any,
    output logic [IW-1:0]        pick
);
    logic [PW-1:0] best;

    // Linear scan upward; "<=" lets later (higher) indices take ties.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        best = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!any || prio[i] <= best)) begin
                any  = 1'b1;
                best = prio[i];
                pick = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lvl_edge_intc.sv
// Top of the interrupt controller: register decode, line configuration,
// mask, and one armed/latched output stage per class (0 = IRQ, 1 = FIQ).
// Assumes single-cycle word accesses with addr[1:0] = 0; unknown offsets
// read 0 and ignore writes.
module lvl_edge_intc
    import intc_pkg::*;
#(
    parameter int N    = LINE_CNT,
    parameter int PW   = PRIO_W,
    parameter int DW   = REG_W,
    parameter int AW   = ADDR_W,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  line_in,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq_o,
    output logic          fiq_o
);
    localparam int IW = $clog2(N);
    localparam int CW = PW + 2;

    logic [N-1:0][PW-1:0] prio_q;
    logic [N-1:0]         sense_q, route_q, mask_q, pend;
    logic [AW-1:0]        cfg_ofs;
    logic [IW-1:0]        cfg_idx;
    logic                 cfg_hit;
    logic                 wr_pend, wr_mask, wr_ctrl, wr_sw, rd_wirq, rd_wfiq;
    logic [1:0]           out_q, armed_q, any_w, ack_w;
    logic [1:0][IW-1:0]   win_q, pick_w;

    // Address decode of strobes and the configuration window.
    assign cfg_ofs = addr - AW'(OFS_CFG);
    assign cfg_idx = cfg_ofs[IW+1:2];
    assign cfg_hit = (addr >= AW'(OFS_CFG)) && (addr[1:0] == 2'b00)
                   && ({2'b00, cfg_ofs[AW-1:2]} < AW'(N));
    assign wr_pend = wr_en && (addr == AW'(OFS_PEND));
    assign wr_mask = wr_en && (addr == AW'(OFS_MASK));
    assign wr_ctrl = wr_en && (addr == AW'(OFS_CTRL));
    assign wr_sw   = wr_en && (addr == AW'(OFS_SWSET));
    assign rd_wirq = rd_en && (addr == AW'(OFS_WIN_IRQ));
    assign rd_wfiq = rd_en && (addr == AW'(OFS_WIN_FIQ));
    assign ack_w   = wr_ctrl ? wdata[1:0] : 2'b00;

    for (genvar g = 0; g < N; g++) begin : g_cfg
        // Per-line configuration word register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[g]  <= '0;
                sense_q[g] <= 1'b0;
                route_q[g] <= 1'b0;
            end else if (wr_en && cfg_hit && (cfg_idx == IW'(g))) begin
                prio_q[g]  <= wdata[PW+1:2];
                sense_q[g] <= wdata[1];
                route_q[g] <= wdata[0];
            end
        end
    end

    // Mask register, all lines masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mask) mask_q <= wdata[N-1:0];
    end

    intc_line_bank #(.N(N), .SYNC(SYNC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .sense      (sense_q),
        .pend_wr    (wr_pend),
        .pend_wdata (wdata[N-1:0]),
        .pick_clr   (rd_wirq | rd_wfiq),
        .pick_idx   (rd_wfiq ? win_q[1] : win_q[0]),
        .sw_wr      (wr_sw),
        .sw_wdata   (wdata[N-1:0]),
        .pend       (pend)
    );

    for (genvar c = 0; c < 2; c++) begin : g_cls
        logic [N-1:0] cand_w;
        assign cand_w = pend & ~mask_q & ((c == 1) ? route_q : ~route_q);

        intc_prio_arb #(.N(N), .PW(PW)) u_arb (
            .cand (cand_w),
            .prio (prio_q),
            .any  (any_w[c]),
            .pick (pick_w[c])
        );

        // Class stage: latch on armed+candidate, release on acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed_q[c] <= 1'b1;
                out_q[c]   <= 1'b0;
                win_q[c]   <= '0;
            end else if ((armed_q[c] || ack_w[c]) && any_w[c]) begin
                armed_q[c] <= 1'b0;
                out_q[c]   <= 1'b1;
                win_q[c]   <= pick_w[c];
            end else if (ack_w[c]) begin
                armed_q[c] <= 1'b1;
                out_q[c]   <= 1'b0;
            end
        end
    end

    assign irq_o = out_q[0];
    assign fiq_o = out_q[1];

    // Read data multiplexer; no side effect here.
    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_PEND))         rdata[N-1:0]  = pend;
        else if (addr == AW'(OFS_MASK))    rdata[N-1:0]  = mask_q;
        else if (addr == AW'(OFS_WIN_IRQ)) rdata[IW-1:0] = win_q[0];
        else if (addr == AW'(OFS_WIN_FIQ)) rdata[IW-1:0] = win_q[1];
        else if (cfg_hit)
            rdata[CW-1:0] = {prio_q[cfg_idx], sense_q[cfg_idx], route_q[cfg_idx]};
    end
endmodule

// File: rtl/intc_checker.sv
// Temporal checks on the interrupt controller, bound into its top.
// Assumes the default register offsets from intc_pkg.
module intc_checker
    import intc_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 32,
    parameter int AW = 8,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          irq_o,
    input logic          fiq_o,
    input logic [IW-1:0] irq_win,
    input logic [IW-1:0] fiq_win,
    input logic          irq_any,
    input logic          fiq_any,
    input logic [N-1:0]  mask
);
    logic [N-1:0] mask_d;
    logic         ack_i, ack_f;

    // One-cycle copy of the mask, matching the cycle a winner is latched.
    always_ff @(posedge clk) mask_d <= mask;

    assign ack_i = wr_en && (addr == AW'(OFS_CTRL)) && wdata[0];
    assign ack_f = wr_en && (addr == AW'(OFS_CTRL)) && wdata[1];

    a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(irq_win)));
    a_r7_fiq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o && !ack_f) |=> (fiq_o && $stable(fiq_win)));
    a_r8_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_any) |=> !irq_o);
    a_r8_fiq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_f && !fiq_any) |=> !fiq_o);
    a_r9_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !mask_d[irq_win]);
    a_r10_swset_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(OFS_SWSET)) |-> (rdata == '0));
    a_r11_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(OFS_CTRL)) |-> (rdata == '0));
endmodule

bind lvl_edge_intc intc_checker #(.N(N), .DW(DW), .AW(AW)) u_intc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o),
    .irq_win (win_q[0]),
    .fiq_win (win_q[1]),
    .irq_any (any_w[0]),
    .fiq_any (any_w[1]),
    .mask    (mask_q)
);

// File: tb/tb_lvl_edge_intc.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every line through edge handling, sweeps
// arbitration over computed patterns, and covers level, mask, routing,
// acknowledge and software-set corner cases.
module tb_lvl_edge_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o, fiq_o;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    lvl_edge_intc dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 8'h00;
    endtask

    function automatic logic [4:0] pf(input int n, input int mode);
        return (mode == 0) ? 5'((n * 11 + 5) % 32) : 5'(n >> 3);
    endfunction

    function automatic logic [31:0] exp_win(input logic [31:0] pat, input int mode);
        logic [4:0] best = 5'h1f;
        logic [31:0] w = 0;
        bit found = 0;
        for (int i = 0; i < 32; i++)
            if (pat[i] && (!found || pf(i, mode) <= best)) begin
                found = 1; best = pf(i, mode); w = i;
            end
        return w;
    endfunction

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(8'h04, v); check("R1 mask", v, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R1 pending", v, 0);
        check("R1 irq", {31'd0, irq_o}, 0);
        check("R1 fiq", {31'd0, fiq_o}, 0);
        for (int n = 0; n < 32; n++) begin
            rd(8'(8'h1C + 4 * n), v); check("R1 cfg", v, 0);
        end

        // R11 config word layout and control read
        wr(8'h1C + 4 * 17, 32'hFFFF_FFFF);
        rd(8'h1C + 4 * 17, v); check("R11 cfg readback", v, 32'h7F);
        rd(8'h18, v); check("R11 ctrl reads 0", v, 0);
        wr(8'h1C + 4 * 17, 0);

        // R2 R5 R7 R8 edge sweep over every line
        wr(8'h04, 0);
        for (int n = 0; n < 32; n++) begin
            line_in[n] = 1'b1; idle(5);
            rd(8'h00, v); check("R2 edge pending", v, 32'h1 << n);
            check("R7 irq raised", {31'd0, irq_o}, 1);
            rd(8'h10, v); check("R5 winner index", v, n);
            rd(8'h00, v); check("R5 edge cleared by read", v, 0);
            idle(4);
            rd(8'h00, v); check("R2 held high no reset", v, 0);
            line_in[n] = 1'b0; idle(3);
            wr(8'h18, 1); check("R8 ack drops irq", {31'd0, irq_o}, 0);
        end

        // R3 R4 R5 level line 5
        wr(8'h1C + 4 * 5, 32'h2);
        line_in[5] = 1'b1; idle(5);
        rd(8'h00, v); check("R3 level pending", v, 32'h20);
        wr(8'h00, 0);
        rd(8'h00, v); check("R4 level kept", v, 32'h20);
        rd(8'h10, v); check("R5 level winner", v, 5);
        rd(8'h00, v); check("R5 level not cleared", v, 32'h20);
        line_in[5] = 1'b0; idle(4);
        rd(8'h00, v); check("R3 level clears on fall", v, 0);
        wr(8'h18, 1);
        wr(8'h1C + 4 * 5, 0);

        // R4 edge line write-clear
        line_in[6] = 1'b1; idle(5);
        wr(8'h00, 32'hFFFF_FFBF);
        rd(8'h00, v); check("R4 edge write clear", v, 0);
        line_in[6] = 1'b0; idle(3);
        wr(8'h18, 1);

        // R6 routing, R7 hold, R8 ack with waiting candidate
        wr(8'h1C + 4 * 9, 32'h1);
        wr(8'h04, 32'hFFFF_FFFF);
        line_in[9] = 1'b1; line_in[3] = 1'b1; idle(5);
        wr(8'h04, 0); idle(2);
        check("R6 fiq raised", {31'd0, fiq_o}, 1);
        check("R6 irq raised", {31'd0, irq_o}, 1);
        rd(8'h10, v); check("R6 irq winner", v, 3);
        rd(8'h14, v); check("R6 fiq winner", v, 9);
        line_in[20] = 1'b1; idle(5);
        check("R7 irq still high", {31'd0, irq_o}, 1);
        rd(8'h00, v); check("R7 new line pending", v, 32'h0010_0000);
        wr(8'h18, 1);
        check("R8 irq stays high", {31'd0, irq_o}, 1);
        rd(8'h10, v); check("R8 new winner", v, 20);
        wr(8'h18, 2); check("R8 fiq released", {31'd0, fiq_o}, 0);
        wr(8'h18, 1); check("R8 irq released", {31'd0, irq_o}, 0);
        line_in = '0; idle(3);
        wr(8'h1C + 4 * 9, 0);

        // R9 mask gating
        wr(8'h04, 32'h0000_1000);
        line_in[12] = 1'b1; idle(5);
        check("R9 masked no irq", {31'd0, irq_o}, 0);
        rd(8'h00, v); check("R9 masked still pending", v, 32'h1000);
        wr(8'h04, 0); idle(1);
        check("R9 unmask raises", {31'd0, irq_o}, 1);
        wr(8'h00, 0); wr(8'h18, 1);
        line_in[12] = 1'b0; idle(3);

        // R10 software set
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h18, 3);
        wr(8'h9C, 32'h0000_0014);
        rd(8'h00, v); check("R10 lowest bit only", v, 32'h4);
        rd(8'h9C, v); check("R10 reads zero", v, 0);
        wr(8'h00, 0);

        // R6 arbitration sweep, two priority layouts
        for (int mode = 0; mode < 2; mode++) begin
            for (int n = 0; n < 32; n++) wr(8'(8'h1C + 4 * n), {25'd0, pf(n, mode), 2'b00});
            for (int k = 0; k < 10; k++) begin
                logic [31:0] pat;
                pat = (32'h9E37_79B9 * (k + 1)) ^ (32'h1 << (k * 3));
                wr(8'h04, 32'hFFFF_FFFF); wr(8'h00, 0); wr(8'h18, 3);
                line_in = pat; idle(5);
                rd(8'h00, v); check("R2 pattern pending", v, pat);
                wr(8'h04, 0); idle(1);
                check("R7 pattern irq", {31'd0, irq_o}, 1);
                rd(8'h10, v); check("R6 pattern winner", v, exp_win(pat, mode));
                line_in = '0; idle(4);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule